// File: doc/BRIEF.md
# Per-Line Sprite Scan Evaluator

This block decides, one table entry at a time, which sprites of a 32-entry sprite attribute table land on the next scanline. Every entry occupies four bytes in video memory. The block reads only the vertical-position byte of each entry. It compares that byte with the upcoming line, using a sprite height set by two mode bits, and appends the index of each covering sprite to a four-slot hit list.

The surrounding line sequencer pulses `line_start` at the opening of each line's scan window. It then issues one `scan_en` pulse for every memory slot it can spare, so the scan can share memory cycles with background fetches. The block reads memory through a combinational port: the address is driven from the current state and the data byte is consumed in the same cycle.

The scan ends in any of three ways:
- a terminator byte is read;
- the index runs past the last entry;
- a fifth covering sprite is found.

A fifth hit raises a sticky overflow flag, which stays set until `ovf_clr` is pulsed. The index of the last entry examined is kept so that status logic can report it.

Top module: `sprite_line_scan`

## Requirements
- R1: The read address is the 7-bit table base placed in address bits 13:7, with the 5-bit entry index in bits 6:2 and zeros in bits 1:0. Right after `line_start` the address equals base shifted left by 7.
- R2: Each `scan_en` pulse evaluates at most one entry. Without a pulse, the index, count, list and last index hold.
- R3: An entry covers the next line when (line + 1 − Y) mod 256 is below the sprite height. The height is 8 rows with neither bit set, 16 with one of `size_big` or `mag_x2` set, and 32 with both set.
- R4: Covering sprites are stored in list slots 0 to 3 in table order, and `hit_cnt` counts them. Slot k is held in `hit_list` bits 5k+4:5k.
- R5: A fifth covering sprite sets `hit_cnt` to 5, sets `ovf_flag` and records its index in `last_idx`. No further entry is evaluated on that line.
- R6: An entry that does not cover the line has its index written to `last_idx`. Hits 1 to 4 leave `last_idx` unchanged.
- R7: A Y byte of 208 ends the scan and sets `last_idx` to 32, and that entry counts as no hit.
- R8: The scan ends after entry 31, and further pulses change nothing.
- R9: `line_start` clears the index, the count and the list. It takes precedence over a `scan_en` in the same cycle, which is then ignored.
- R10: `ovf_flag` is sticky across lines and is cleared only by `ovf_clr`. A fifth hit in the same cycle as `ovf_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Opens a new line's scan window |
| scan_en | input | 1 | Evaluate one entry this cycle |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| line_num | input | 8 | Current scanline counter |
| sat_base | input | 7 | Attribute table base register |
| size_big | input | 1 | Doubles sprite height |
| mag_x2 | input | 1 | Doubles sprite height again |
| vram_addr | output | 14 | Read address of the Y byte |
| vram_data | input | 8 | Byte returned for `vram_addr`, same cycle |
| hit_list | output | 20 | Four 5-bit indices of covering sprites |
| hit_cnt | output | 3 | Covering sprites found, 0 to 5 |
| ovf_flag | output | 1 | Sticky fifth-sprite flag |
| last_idx | output | 6 | Last examined or fifth sprite index |

## Verification
Two conflicts can arise in a single cycle. The first is a fifth hit landing in the same cycle as an overflow clear: the bench builds a table whose first five entries all cover the line and drives `ovf_clr` together with the fifth `scan_en` pulse, then expects the flag set. The second is a line restart arriving with a scan pulse: the bench asserts both together and expects a zero count with the address still at the table base, after which a single pulse must give the one-entry result. Randomized tables are placed around the line to hit the boundary heights, and each line is checked after a random number of pulses against a bench model.

// File: rtl/spr_scan_pkg.sv
package spr_scan_pkg;
  typedef logic [7:0] ybyte_t;

  // Sprite height in rows from the two mode bits.
  function automatic logic [7:0] spr_height(input logic [7:0] base_h,
                                            input logic size_b,
                                            input logic mag_b);
    logic [7:0] h;
    h = base_h;
    if (size_b) h = h << 1;
    if (mag_b)  h = h << 1;
    return h;
  endfunction
endpackage

// File: rtl/spr_scan_addr.sv
module spr_scan_addr #(
  parameter int BASE_W = 7,
  parameter int SLOT_W = 5,
  parameter int ADDR_W = 14
) (
  input  logic [BASE_W-1:0] base_reg,
  input  logic [SLOT_W-1:0] entry_idx,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int ENTRY_SH = 2;

  always_comb begin
    rd_addr = '0;
    rd_addr[ADDR_W-1 -: BASE_W]      = base_reg;
    rd_addr[ENTRY_SH +: SLOT_W]      = entry_idx;
  end
endmodule

// File: rtl/spr_scan_hit.sv
module spr_scan_hit
  import spr_scan_pkg::*;
#(
  parameter int BASE_H = 8
) (
  input  logic [7:0] line_num,
  input  ybyte_t     ypos,
  input  logic       size_big,
  input  logic       mag_x2,
  output logic       covers
);
  logic [7:0] row_off;
  logic [7:0] height;

  always_comb begin
    height  = spr_height(8'(BASE_H), size_big, mag_x2);
    row_off = line_num + 8'd1 - ypos;
    covers  = row_off < height;
  end
endmodule

// File: rtl/spr_scan_list.sv
module spr_scan_list #(
  parameter int LIST_N = 4,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [CNT_W-1:0]         wr_slot,
  input  logic [SLOT_W-1:0]        wr_idx,
  output logic [LIST_N*SLOT_W-1:0] list_flat
);
  for (genvar g = 0; g < LIST_N; g++) begin : g_slot
    logic [SLOT_W-1:0] ent_q, ent_d;
    logic              ent_we;

    always_comb begin
      ent_we = clr || (wr_en && (wr_slot == CNT_W'(g)));
      ent_d  = clr ? '0 : wr_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_we) ent_q <= ent_d;
    end

    assign list_flat[g*SLOT_W +: SLOT_W] = ent_q;
  end

  // R4: writes only ever target an existing slot
  assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_slot < CNT_W'(LIST_N)));
endmodule

// File: rtl/sprite_line_scan.sv
module sprite_line_scan
  import spr_scan_pkg::*;
#(
  parameter int   NUM_SPR = 32,
  parameter int   LIST_N  = 4,
  parameter int   BASE_W  = 7,
  parameter int   ADDR_W  = 14,
  parameter int   BASE_H  = 8,
  parameter logic [7:0] TERM_Y = 8'd208
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_start,
  input  logic                     scan_en,
  input  logic                     ovf_clr,
  input  logic [7:0]               line_num,
  input  logic [BASE_W-1:0]        sat_base,
  input  logic                     size_big,
  input  logic                     mag_x2,
  output logic [ADDR_W-1:0]        vram_addr,
  input  logic [7:0]               vram_data,
  output logic [LIST_N*$clog2(NUM_SPR)-1:0] hit_list,
  output logic [$clog2(LIST_N+2)-1:0]       hit_cnt,
  output logic                     ovf_flag,
  output logic [$clog2(NUM_SPR)+1-1:0]      last_idx
);
  localparam int SLOT_W = $clog2(NUM_SPR);
  localparam int IDX_W  = SLOT_W + 1;
  localparam int CNT_W  = $clog2(LIST_N + 2);
  localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(NUM_SPR);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(LIST_N);
  localparam logic [CNT_W-1:0] CNT_FIFTH = CNT_W'(LIST_N + 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             ovf_q, ovf_d;
  logic             scan_done, step, is_term, covers, list_we, fifth_hit;

  spr_scan_addr #(.BASE_W(BASE_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_addr (
    .base_reg (sat_base),
    .entry_idx(idx_q[SLOT_W-1:0]),
    .rd_addr  (vram_addr)
  );

  spr_scan_hit #(.BASE_H(BASE_H)) u_hit (
    .line_num(line_num),
    .ypos    (vram_data),
    .size_big(size_big),
    .mag_x2  (mag_x2),
    .covers  (covers)
  );

  spr_scan_list #(.LIST_N(LIST_N), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (line_start),
    .wr_en    (list_we),
    .wr_slot  (cnt_q),
    .wr_idx   (idx_q[SLOT_W-1:0]),
    .list_flat(hit_list)
  );

  always_comb begin
    scan_done = (idx_q == IDX_END) || (cnt_q == CNT_FIFTH);
    step      = scan_en && !line_start && !scan_done;
    is_term   = (vram_data == TERM_Y);
    list_we   = step && !is_term && covers && (cnt_q < CNT_FULL);
    fifth_hit = step && !is_term && covers && (cnt_q == CNT_FULL);

    idx_d  = idx_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (line_start) begin
      idx_d = '0;
      cnt_d = '0;
    end else if (step) begin
      if (is_term) begin
        idx_d  = IDX_END;
        last_d = IDX_END;
      end else begin
        idx_d = idx_q + IDX_W'(1);
        if (covers) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_FULL) last_d = idx_q;
        end else begin
          last_d = idx_q;
        end
      end
    end

    if (fifth_hit)    ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      ovf_q  <= ovf_d;
    end
  end

  assign hit_cnt  = cnt_q;
  assign ovf_flag = ovf_q;
  assign last_idx = last_q;

  // R8: index never passes the table end
  assert_idx_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_END);

  // R2: index moves only on a pulse, by one or to the end marker
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((idx_q != $past(idx_q)) && !$past(line_start)) |->
      ($past(scan_en) && ((idx_q == $past(idx_q) + IDX_W'(1)) || (idx_q == IDX_END))));

  // R4: count grows by at most one per cycle within a line
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ((hit_cnt == $past(hit_cnt)) || (hit_cnt == $past(hit_cnt) + CNT_W'(1))));

  // R5: after the fifth hit nothing more is evaluated
  assert_stop_after_fifth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_cnt == CNT_FIFTH) && !line_start) |=> ($stable(idx_q) && $stable(hit_cnt) && $stable(last_idx)));

  // R5: reaching five hits raises the flag
  assert_fifth_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_cnt == CNT_FIFTH) && ($past(hit_cnt) == CNT_FULL)) |-> ovf_flag);

  // R7: terminator ends the scan without a hit
  assert_term_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_term) |=> ((idx_q == IDX_END) && (last_idx == IDX_END) && $stable(hit_cnt)));

  // R9: line restart clears the scan state
  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> ((idx_q == '0) && (hit_cnt == '0)));

  // R10: flag only falls through an explicit clear
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: tb/sim_sprite_line_scan.sv
`timescale 1ns/1ps
module sim_sprite_line_scan;
  logic        clk, rst_n;
  logic        line_start, scan_en, ovf_clr;
  logic [7:0]  line_num;
  logic [6:0]  sat_base;
  logic        size_big, mag_x2;
  logic [13:0] vram_addr;
  logic [7:0]  vram_data;
  logic [19:0] hit_list;
  logic [2:0]  hit_cnt;
  logic        ovf_flag;
  logic [5:0]  last_idx;

  logic [7:0] sat_mem [0:127];
  assign vram_data = sat_mem[vram_addr[6:0]];

  int n_run, n_fail;
  bit finished;

  int m_cnt, m_last, m_list [0:3];
  bit m_fifth;
  int exp_last;
  bit exp_ovf;

  sprite_line_scan u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .scan_en(scan_en),
    .ovf_clr(ovf_clr), .line_num(line_num), .sat_base(sat_base),
    .size_big(size_big), .mag_x2(mag_x2), .vram_addr(vram_addr),
    .vram_data(vram_data), .hit_list(hit_list), .hit_cnt(hit_cnt),
    .ovf_flag(ovf_flag), .last_idx(last_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; returns at the next falling edge.
  task automatic cyc(input logic se, input logic ls, input logic cl);
    scan_en = se; line_start = ls; ovf_clr = cl;
    @(posedge clk);
    @(negedge clk);
    scan_en = 1'b0; line_start = 1'b0; ovf_clr = 1'b0;
  endtask

  function automatic int height();
    int h;
    h = 8;
    if (size_big) h = h * 2;
    if (mag_x2)   h = h * 2;
    return h;
  endfunction

  // Bench model of n scan pulses from the start of a line.
  task automatic model(input int n);
    int idx;
    logic [7:0] y, d;
    m_cnt = 0; m_fifth = 0; idx = 0; m_last = exp_last;
    for (int s = 0; s < n; s++) begin
      if (idx == 32 || m_cnt == 5) break;
      y = sat_mem[idx*4];
      if (y == 8'd208) begin
        idx = 32; m_last = 32;
        continue;
      end
      d = line_num + 8'd1 - y;
      if (int'(d) < height()) begin
        if (m_cnt < 4) m_list[m_cnt] = idx;
        m_cnt++;
        if (m_cnt == 5) begin m_last = idx; m_fifth = 1; end
      end else begin
        m_last = idx;
      end
      idx++;
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R4 count"}, int'(hit_cnt), m_cnt);
    chk({tag, " R6 last"}, int'(last_idx), m_last);
    chk({tag, " R5/R10 flag"}, int'(ovf_flag), int'(exp_ovf));
    for (int k = 0; k < 4; k++)
      if (k < m_cnt) chk({tag, " R4 slot"}, int'(hit_list[k*5 +: 5]), m_list[k]);
  endtask

  task automatic run_line(input int npulses, input string tag);
    cyc(1'b0, 1'b1, 1'b0);
    chk({tag, " R1 addr"}, int'(vram_addr), int'(sat_base) << 7);
    for (int k = 0; k < npulses; k++) cyc(1'b1, 1'b0, 1'b0);
    model(npulses);
    exp_last = m_last;
    if (m_fifth) exp_ovf = 1'b1;
    compare_all(tag);
  endtask

  task automatic fill_rand();
    int h, r;
    h = height();
    for (int i = 0; i < 128; i++) sat_mem[i] = 8'($urandom);
    for (int i = 0; i < 32; i++) begin
      r = int'($urandom % 16);
      if (r == 0)       sat_mem[i*4] = 8'd208;
      else if (r < 9)   sat_mem[i*4] = line_num + 8'd1 - 8'($urandom % (h + 3));
      else              sat_mem[i*4] = 8'($urandom);
    end
  endtask

  task automatic fill_miss();
    for (int i = 0; i < 32; i++) sat_mem[i*4] = line_num + 8'd100;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    n_run = 0; n_fail = 0; finished = 0;
    exp_last = 0; exp_ovf = 0;
    rst_n = 1'b0; line_start = 0; scan_en = 0; ovf_clr = 0;
    line_num = 8'd50; sat_base = 7'h15; size_big = 0; mag_x2 = 0;
    for (int i = 0; i < 128; i++) sat_mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R9 reset count", int'(hit_cnt), 0);
    chk("R10 reset flag", int'(ovf_flag), 0);
    chk("R6 reset last", int'(last_idx), 0);
    chk("R4 reset list", int'(hit_list), 0);

    // R7: terminator at entry 0
    fill_miss();
    sat_mem[0] = 8'd208;
    run_line(5, "term0 R7");
    chk("R7 last at end", int'(last_idx), 32);

    // R8 / R6: all misses, extra pulses past the end
    fill_miss();
    run_line(40, "allmiss R8");
    chk("R8 last is 31", int'(last_idx), 31);

    // R3: boundary heights for every size/mag combination
    for (int c = 0; c < 4; c++) begin
      size_big = c[0]; mag_x2 = c[1];
      fill_miss();
      sat_mem[0] = line_num + 8'd1 - 8'(height() - 1);
      sat_mem[4] = line_num + 8'd1 - 8'(height());
      sat_mem[8] = 8'd208;
      run_line(6, "height R3");
      chk("R3 edge hit count", int'(hit_cnt), 1);
    end
    size_big = 0; mag_x2 = 0;

    // R5 + R10: fifth hit together with a clear; flag must stay set
    fill_miss();
    for (int i = 0; i < 6; i++) sat_mem[i*4] = line_num - 8'd2;
    cyc(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R10 set beats clear", int'(ovf_flag), 1);
    chk("R5 count five", int'(hit_cnt), 5);
    chk("R5 last is fifth", int'(last_idx), 4);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0);
    chk("R5 no more scanning", int'(last_idx), 4);
    chk("R5 count held", int'(hit_cnt), 5);
    for (int k = 0; k < 4; k++) chk("R4 ordered slot", int'(hit_list[k*5 +: 5]), k);
    exp_last = 4; exp_ovf = 1;
    cyc(1'b0, 1'b1, 1'b0);
    chk("R10 sticky over line", int'(ovf_flag), 1);
    cyc(1'b0, 1'b0, 1'b1);
    exp_ovf = 0;
    chk("R10 clear", int'(ovf_flag), 0);

    // R9: restart and pulse in the same cycle
    fill_miss();
    sat_mem[0] = line_num;
    sat_mem[4] = line_num;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    chk("R9 count after restart", int'(hit_cnt), 0);
    chk("R9 pulse ignored addr", int'(vram_addr), int'(sat_base) << 7);
    cyc(1'b1, 1'b0, 1'b0);
    model(1);
    chk("R2 one entry per pulse", int'(hit_cnt), 1);
    chk("R2 one entry slot", int'(hit_list[4:0]), 0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R2 hold without pulse", int'(hit_cnt), 1);

    // Random lines with random pulse budgets
    for (int t = 0; t < 40; t++) begin
      line_num = 8'($urandom);
      sat_base = 7'($urandom);
      size_big = 1'($urandom);
      mag_x2   = 1'($urandom);
      fill_rand();
      run_line(int'($urandom % 40) + 1, "rand R3/R4/R6");
      if (t % 7 == 0 && exp_ovf) begin
        cyc(1'b0, 1'b0, 1'b1);
        exp_ovf = 0;
        chk("R10 rand clear", int'(ovf_flag), 0);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule